// File: doc/BRIEF.md
# Soft Stereo Attenuator with Silence Detection

This block sits in the sample path of a stereo audio converter, between the serial-to-parallel front end and the interpolation filters. For each stereo pair of 24-bit two's-complement samples it applies a per-channel linear gain and registers the scaled result. The gain comes from an 8-bit attenuation code, optionally shared by both channels, or is zero while soft mute is on. A new code or a mute request never takes effect in a single jump. The working gain walks toward its new target one step of 1/256 at a time, so a full swing from unity to silence takes 1024 sample periods.

The block also watches each input channel for a sustained idle pattern. An idle sample has its upper 20 bits uniform (all zeros or all ones) and is identical to the sample before it. After 8192 consecutive idle samples that channel is flagged. With detection enabled, the flagged channel's output is forced to mid-scale (zero) at once. A mono control can copy one chosen input channel onto both outputs. When it does, the silence flag of that chosen channel governs both outputs.

Top module: `softAttenZd`

## Requirements
- R1: The attenuation code maps to a 9-bit linear gain: code 0x00 gives 256 (unity), any code n from 0x01 to 0xFF gives 255−n, so 0xFF gives 0 (silence); the output equals sample × gain / 256.
- R2: With `attenIndiv` = 0 both channels take their target from `attenLeft` and `attenRight` has no effect; with `attenIndiv` = 1 the right channel takes its target from `attenRight`.
- R3: While `muteOn` = 1 the target of both channels is 0; from unity the gain reaches 0 within 1024 sample strobes, and after release it returns to unity within 1024 strobes.
- R4: The working gain of each channel moves by exactly one LSB toward its target on every fourth sample strobe, counted from reset, and never changes otherwise.
- R5: One clock after a strobe `outValid` pulses and the outputs carry the product of that strobe's routed sample and the gain in force before the strobe, divided by 256 with rounding toward zero; between strobes the outputs hold.
- R6: A channel's counter advances on a strobe whose sample has bits 23:4 all 0 or all 1 and equals the previous sample on that channel; any other sample clears it; the channel is flagged once 8192 consecutive idle samples have been counted.
- R7: Left and right are judged independently, and `zeroBoth` is high exactly when both `zeroLeft` and `zeroRight` are high.
- R8: When an output's source channel is flagged, that output reads zero in the same cycle the flag rises, without waiting for a strobe.
- R9: With `zeroDetEnN` = 1 all zero flags read 0 and no output is forced; the idle counts are kept, so flags reappear at once when detection is re-enabled.
- R10: With `monoOn` = 1 both outputs are driven from the left input when `monoPickLeft` = 1 and from the right input when it is 0, each scaled by its own channel gain; with `monoOn` = 0 the routing is straight stereo.
- R11: After reset both gains are unity, the outputs are zero, `outValid` is low and no zero flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a new stereo pair |
| inLeft | input | 24 | Left input sample, two's complement |
| inRight | input | 24 | Right input sample, two's complement |
| attenLeft | input | 8 | Left (or common) attenuation code |
| attenRight | input | 8 | Right attenuation code, used when individual |
| attenIndiv | input | 1 | 1: individual codes, 0: left code for both |
| muteOn | input | 1 | Soft mute request, active high |
| zeroDetEnN | input | 1 | Silence detection enable, active low |
| monoOn | input | 1 | 1: mono output, 0: stereo |
| monoPickLeft | input | 1 | Mono source select, 1 left, 0 right |
| outValid | output | 1 | Pulses one clock after each strobe |
| outLeft | output | 24 | Scaled left output sample |
| outRight | output | 24 | Scaled right output sample |
| zeroLeft | output | 1 | Left channel silence flag |
| zeroRight | output | 1 | Right channel silence flag |
| zeroBoth | output | 1 | Both channels flagged |

## Verification
The bench drives long runs of random samples and changing codes against a bench model. That model steps the gain every fourth strobe and applies round-toward-zero to negative products. A design that rounded down would be off by one on every negative sample, and one that stepped every strobe would settle four times early. Directed runs cover the exact 8192-sample threshold and a single changed low nibble that must restart the count. A constant value with non-uniform upper bits must never be flagged. In common mode, a right code that should be ignored is set to a very different value, so a design that leaked it would show a wrong right output. Mono routing of a flagged channel checks that the forced zero follows the chosen source. Toggling the enable checks that flags and forcing vanish and return without losing the count.

// File: rtl/attenPkg.sv
package attenPkg;

  // Strobes and selects handed from the control half to the datapath half.
  typedef struct packed {
    logic load;        // a new stereo pair is being accepted
    logic monoOn;      // copy one source to both lanes
    logic pickLeft;    // mono source: 1 left, 0 right
    logic forceLeft;   // left lane's source channel is flagged silent
    logic forceRight;  // right lane's source channel is flagged silent
  } pathCtl_t;

endpackage

// File: rtl/gainRamp.sv
module gainRamp #(
  parameter int GAIN_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepNow,
  input  logic [GAIN_W-1:0] target,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gain <= UNITY;
    end else if (stepNow) begin
      if (gain < target) begin
        gain <= gain + GAIN_W'(1);
      end else if (gain > target) begin
        gain <= gain - GAIN_W'(1);
      end
    end
  end

  // R4
  gain_moves_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gain != $past(gain)) |-> $past(stepNow));

  // R4
  gain_unit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gain != $past(gain)) |-> ((gain == $past(gain) + GAIN_W'(1)) || (gain == $past(gain) - GAIN_W'(1))));

  // R1
  gain_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    gain <= UNITY);

endmodule

// File: rtl/zeroWatch.sv
module zeroWatch #(
  parameter int DATA_W   = 24,
  parameter int ZERO_LEN = 8192,
  parameter int LSB_IGN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              take,
  input  logic [DATA_W-1:0] sample,
  input  logic              enable,
  output logic              flag
);

  localparam int CNT_W = $clog2(ZERO_LEN + 1);
  localparam int UP_W  = DATA_W - LSB_IGN;

  logic [DATA_W-1:0] prevSample;
  logic [CNT_W-1:0]  quietCnt;
  logic [UP_W-1:0]   upperBits;
  logic              uniformUpper;
  logic              quiet;
  logic              full;

  assign upperBits    = sample[DATA_W-1:LSB_IGN];
  assign uniformUpper = (&upperBits) || (~|upperBits);
  assign quiet        = uniformUpper && (sample == prevSample);
  assign full         = (quietCnt == CNT_W'(ZERO_LEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '0;
      quietCnt   <= '0;
    end else if (take) begin
      prevSample <= sample;
      if (!quiet) begin
        quietCnt <= '0;
      end else if (!full) begin
        quietCnt <= quietCnt + CNT_W'(1);
      end
    end
  end

  assign flag = enable && full;

  // R6
  count_changes_on_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt != $past(quietCnt)) |-> $past(take));

  // R6
  count_climbs_or_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt != $past(quietCnt)) |-> ((quietCnt == '0) || (quietCnt == $past(quietCnt) + CNT_W'(1))));

  // R6
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rstN)
    quietCnt <= CNT_W'(ZERO_LEN));

endmodule

// File: rtl/attenCtrl.sv
module attenCtrl
  import attenPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CODE_W   = 8,
  parameter int STEP_DIV = 4,
  parameter int ZERO_LEN = 8192,
  parameter int LSB_IGN  = 4,
  localparam int GAIN_W  = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [CODE_W-1:0] attenLeft,
  input  logic [CODE_W-1:0] attenRight,
  input  logic              attenIndiv,
  input  logic              muteOn,
  input  logic              zeroDetEnN,
  input  logic              monoOn,
  input  logic              monoPickLeft,
  output pathCtl_t          pathCtl,
  output logic [GAIN_W-1:0] gainLeft,
  output logic [GAIN_W-1:0] gainRight,
  output logic              zeroLeft,
  output logic              zeroRight,
  output logic              zeroBoth
);

  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);
  localparam int DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

  function automatic logic [GAIN_W-1:0] codeToGain(input logic [CODE_W-1:0] code);
    if (code == '0) begin
      return UNITY;
    end
    return GAIN_W'({CODE_W{1'b1}}) - GAIN_W'(code);
  endfunction

  // Ramp pacing: one gain step every STEP_DIV accepted samples.
  logic stepNow;

  generate
    if (STEP_DIV > 1) begin : g_div
      logic [DIV_W-1:0] stepCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stepCnt <= '0;
        end else if (sampleValid) begin
          stepCnt <= (stepCnt == DIV_W'(STEP_DIV - 1)) ? '0 : stepCnt + DIV_W'(1);
        end
      end
      assign stepNow = sampleValid && (stepCnt == DIV_W'(STEP_DIV - 1));
    end else begin : g_nodiv
      assign stepNow = sampleValid;
    end
  endgenerate

  logic [CODE_W-1:0] codeSel [2];
  logic [GAIN_W-1:0] target  [2];
  logic [GAIN_W-1:0] gain    [2];
  logic [DATA_W-1:0] chIn    [2];
  logic              chZero  [2];

  assign codeSel[0] = attenLeft;
  assign codeSel[1] = attenIndiv ? attenRight : attenLeft;
  assign chIn[0]    = inLeft;
  assign chIn[1]    = inRight;

  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      assign target[ch] = muteOn ? '0 : codeToGain(codeSel[ch]);

      gainRamp #(.GAIN_W(GAIN_W)) u_ramp (
        .clk     (clk),
        .rstN    (rstN),
        .stepNow (stepNow),
        .target  (target[ch]),
        .gain    (gain[ch])
      );

      zeroWatch #(.DATA_W(DATA_W), .ZERO_LEN(ZERO_LEN), .LSB_IGN(LSB_IGN)) u_watch (
        .clk    (clk),
        .rstN   (rstN),
        .take   (sampleValid),
        .sample (chIn[ch]),
        .enable (!zeroDetEnN),
        .flag   (chZero[ch])
      );
    end
  endgenerate

  assign gainLeft  = gain[0];
  assign gainRight = gain[1];
  assign zeroLeft  = chZero[0];
  assign zeroRight = chZero[1];
  assign zeroBoth  = chZero[0] && chZero[1];

  logic pickedZero;
  assign pickedZero = monoPickLeft ? chZero[0] : chZero[1];

  always_comb begin
    pathCtl            = '0;
    pathCtl.load       = sampleValid;
    pathCtl.monoOn     = monoOn;
    pathCtl.pickLeft   = monoPickLeft;
    pathCtl.forceLeft  = monoOn ? pickedZero : chZero[0];
    pathCtl.forceRight = monoOn ? pickedZero : chZero[1];
  end

  // R2
  common_gain_lockstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!attenIndiv && !$past(attenIndiv) && $past(gainLeft == gainRight)) |-> (gainLeft == gainRight));

  // R9
  disabled_no_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroDetEnN |-> !(zeroLeft || zeroRight || zeroBoth));

endmodule

// File: rtl/attenPath.sv
module attenPath
  import attenPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          pathCtl,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [GAIN_W-1:0] gainLeft,
  input  logic [GAIN_W-1:0] gainRight,
  output logic              outValid,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight
);

  localparam int FRAC   = GAIN_W - 1;
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((1 << FRAC) - 1);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC;

  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] src     [2];
  logic [GAIN_W-1:0] laneGain[2];
  logic              laneZero[2];
  logic [DATA_W-1:0] held    [2];
  logic [DATA_W-1:0] shown   [2];

  assign picked      = pathCtl.pickLeft ? inLeft : inRight;
  assign src[0]      = pathCtl.monoOn ? picked : inLeft;
  assign src[1]      = pathCtl.monoOn ? picked : inRight;
  assign laneGain[0] = gainLeft;
  assign laneGain[1] = gainRight;
  assign laneZero[0] = pathCtl.forceLeft;
  assign laneZero[1] = pathCtl.forceRight;

  generate
    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      logic signed [PROD_W-1:0] srcExt;
      logic signed [PROD_W-1:0] gainExt;
      logic signed [PROD_W-1:0] prod;
      logic signed [PROD_W-1:0] adj;
      logic signed [PROD_W-1:0] shifted;

      always_comb begin
        srcExt  = PROD_W'($signed(src[ln]));
        gainExt = $signed(PROD_W'({1'b0, laneGain[ln]}));
        prod    = srcExt * gainExt;
        // Negative products are biased up so the shift rounds toward zero.
        adj     = prod + (prod[PROD_W-1] ? BIAS : '0);
        shifted = adj >>> FRAC;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          held[ln] <= '0;
        end else if (pathCtl.load) begin
          held[ln] <= shifted[DATA_W-1:0];
        end
      end

      assign shown[ln] = laneZero[ln] ? '0 : held[ln];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else begin
      outValid <= pathCtl.load;
    end
  end

  assign outLeft  = shown[0];
  assign outRight = shown[1];

  // R5
  hold_between_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(pathCtl.load) |-> ($stable(held[0]) && $stable(held[1])));

  // R5
  unity_passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && !pathCtl.monoOn && gainLeft == UNITY) |=> (held[0] == $past(inLeft)));

  // R10
  mono_lanes_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && pathCtl.monoOn && gainLeft == gainRight) |=> (held[0] == held[1]));

  // R1
  silent_gain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pathCtl.load && gainRight == '0) |=> (held[1] == '0));

endmodule

// File: rtl/softAttenZd.sv
module softAttenZd
  import attenPkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CODE_W   = 8,
  parameter int STEP_DIV = 4,
  parameter int ZERO_LEN = 8192,
  parameter int LSB_IGN  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] inLeft,
  input  logic [DATA_W-1:0] inRight,
  input  logic [CODE_W-1:0] attenLeft,
  input  logic [CODE_W-1:0] attenRight,
  input  logic              attenIndiv,
  input  logic              muteOn,
  input  logic              zeroDetEnN,
  input  logic              monoOn,
  input  logic              monoPickLeft,
  output logic              outValid,
  output logic [DATA_W-1:0] outLeft,
  output logic [DATA_W-1:0] outRight,
  output logic              zeroLeft,
  output logic              zeroRight,
  output logic              zeroBoth
);

  localparam int GAIN_W = CODE_W + 1;

  pathCtl_t          pathCtl;
  logic [GAIN_W-1:0] gainLeft;
  logic [GAIN_W-1:0] gainRight;

  attenCtrl #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .STEP_DIV (STEP_DIV),
    .ZERO_LEN (ZERO_LEN),
    .LSB_IGN  (LSB_IGN)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .inLeft       (inLeft),
    .inRight      (inRight),
    .attenLeft    (attenLeft),
    .attenRight   (attenRight),
    .attenIndiv   (attenIndiv),
    .muteOn       (muteOn),
    .zeroDetEnN   (zeroDetEnN),
    .monoOn       (monoOn),
    .monoPickLeft (monoPickLeft),
    .pathCtl      (pathCtl),
    .gainLeft     (gainLeft),
    .gainRight    (gainRight),
    .zeroLeft     (zeroLeft),
    .zeroRight    (zeroRight),
    .zeroBoth     (zeroBoth)
  );

  attenPath #(
    .DATA_W (DATA_W),
    .GAIN_W (GAIN_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .pathCtl   (pathCtl),
    .inLeft    (inLeft),
    .inRight   (inRight),
    .gainLeft  (gainLeft),
    .gainRight (gainRight),
    .outValid  (outValid),
    .outLeft   (outLeft),
    .outRight  (outRight)
  );

  // R7
  both_flag_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroBoth |-> (zeroLeft && zeroRight));

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outLeft == '0 && outRight == '0));

endmodule

// File: tb/softAttenZd_bench.sv
module softAttenZd_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] inLeft = '0;
  logic [23:0] inRight = '0;
  logic [7:0]  attenLeft = '0;
  logic [7:0]  attenRight = '0;
  logic        attenIndiv = 1'b0;
  logic        muteOn = 1'b0;
  logic        zeroDetEnN = 1'b1;
  logic        monoOn = 1'b0;
  logic        monoPickLeft = 1'b1;
  logic        outValid;
  logic [23:0] outLeft;
  logic [23:0] outRight;
  logic        zeroLeft;
  logic        zeroRight;
  logic        zeroBoth;

  softAttenZd u_softAttenZd (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .inLeft(inLeft), .inRight(inRight),
    .attenLeft(attenLeft), .attenRight(attenRight), .attenIndiv(attenIndiv),
    .muteOn(muteOn), .zeroDetEnN(zeroDetEnN),
    .monoOn(monoOn), .monoPickLeft(monoPickLeft),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight),
    .zeroLeft(zeroLeft), .zeroRight(zeroRight), .zeroBoth(zeroBoth)
  );

  always #10 clk = ~clk;

  int totalChecks = 0;
  int failChecks  = 0;
  bit finished    = 0;

  // Bench model state
  int gL = 256, gR = 256, stepCnt = 0, cntL = 0, cntR = 0;
  logic [23:0] prevL = '0, prevR = '0;
  logic [23:0] rawL = '0, rawR = '0, expL = '0, expR = '0;
  logic [23:0] lastS;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    totalChecks++;
    if (!ok) begin
      failChecks++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec(input logic [7:0] c);
    return (c == 8'h00) ? 256 : 255 - int'(c);
  endfunction

  function automatic logic [23:0] scale(input logic [23:0] s, input int g);
    longint v, p, q;
    logic [63:0] t;
    v = longint'($signed(s));
    p = v * longint'(g);
    if (p < 0) q = -((-p) / 256);
    else       q = p / 256;
    t = q;
    return t[23:0];
  endfunction

  function automatic bit isQuiet(input logic [23:0] s, input logic [23:0] prev);
    return ((s[23:4] == 20'h0) || (s[23:4] == 20'hFFFFF)) && (s == prev);
  endfunction

  function automatic int moveTo(input int g, input int t);
    if (g < t) return g + 1;
    if (g > t) return g - 1;
    return g;
  endfunction

  // Entered at a falling edge; returns at the next falling edge.
  task automatic strobe(input logic [23:0] l, input logic [23:0] r, input string tag);
    bit fl, fr, fsL, fsR;
    logic [23:0] srcL, srcR;
    int tL, tR;
    inLeft = l; inRight = r; sampleValid = 1'b1;
    if (isQuiet(l, prevL)) begin if (cntL < 8192) cntL++; end else cntL = 0;
    if (isQuiet(r, prevR)) begin if (cntR < 8192) cntR++; end else cntR = 0;
    prevL = l; prevR = r;
    fl = !zeroDetEnN && (cntL == 8192);
    fr = !zeroDetEnN && (cntR == 8192);
    srcL = monoOn ? (monoPickLeft ? l : r) : l;
    srcR = monoOn ? (monoPickLeft ? l : r) : r;
    fsL  = monoOn ? (monoPickLeft ? fl : fr) : fl;
    fsR  = monoOn ? (monoPickLeft ? fl : fr) : fr;
    rawL = scale(srcL, gL); rawR = scale(srcR, gR);
    expL = fsL ? 24'h0 : rawL;
    expR = fsR ? 24'h0 : rawR;
    tL = muteOn ? 0 : dec(attenLeft);
    tR = muteOn ? 0 : dec(attenIndiv ? attenRight : attenLeft);
    if (stepCnt == 3) begin gL = moveTo(gL, tL); gR = moveTo(gR, tR); end
    stepCnt = (stepCnt + 1) % 4;
    @(negedge clk);
    sampleValid = 1'b0;
    chk(outValid == 1'b1, {tag, " R5 valid"}, 32'(outValid), 32'd1);
    chk(outLeft == expL, {tag, " left"}, 32'(outLeft), 32'(expL));
    chk(outRight == expR, {tag, " right"}, 32'(outRight), 32'(expR));
    chk(zeroLeft == fl && zeroRight == fr, "R6 flags", {30'd0, zeroLeft, zeroRight}, {30'd0, fl, fr});
    chk(zeroBoth == (fl && fr), "R7 both", 32'(zeroBoth), 32'(fl && fr));
  endtask

  task automatic idle(input int n);
    sampleValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(outValid == 1'b0 && outLeft == expL && outRight == expR, "R5 hold",
          {8'd0, outLeft}, {8'd0, expL});
    end
  endtask

  function automatic logic [23:0] rnd();
    return 24'($urandom());
  endfunction

  task automatic randomRun(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      strobe(rnd(), rnd(), tag);
      if ($urandom_range(7) == 0) idle(1);
    end
  endtask

  task automatic holdRun(input logic [23:0] l, input logic [23:0] r, input int n, input string tag);
    for (int i = 0; i < n; i++) strobe(l, r, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(outValid == 1'b0 && outLeft == 24'h0 && outRight == 24'h0, "R11 outputs", {8'd0, outLeft}, 32'd0);
    chk(!zeroLeft && !zeroRight && !zeroBoth, "R11 flags", {29'd0, zeroLeft, zeroRight, zeroBoth}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && outLeft == 24'h0, "R11 after release", {8'd0, outLeft}, 32'd0);

    // R5 unity passthrough and rounding
    randomRun(200, "R5");
    strobe(24'hFFFFFF, 24'h800000, "R5 extremes");

    // R2 common mode: right code must be ignored
    attenLeft = 8'h01; attenRight = 8'h80; attenIndiv = 1'b0;
    randomRun(1100, "R2 common");
    strobe(24'h7FFFFF, 24'h7FFFFF, "R2 settled");
    chk(outRight == scale(24'h7FFFFF, 254), "R2 right uses left code", 32'(outRight), 32'(scale(24'h7FFFFF, 254)));

    // R1 individual codes, deep attenuation and silence
    attenIndiv = 1'b1; attenRight = 8'hFC;
    randomRun(1100, "R2 indiv");
    strobe(24'h812345, 24'h812345, "R1 FC");
    chk(outRight == scale(24'h812345, 3), "R1 code FC", 32'(outRight), 32'(scale(24'h812345, 3)));
    attenLeft = 8'hFF;
    randomRun(1100, "R1");
    strobe(24'h7FFFFF, 24'h000001, "R1 FF");
    chk(outLeft == 24'h0, "R1 code FF silent", 32'(outLeft), 32'd0);

    // R4 ramping between changing codes
    for (int k = 0; k < 10; k++) begin
      attenLeft = 8'($urandom()); attenRight = 8'($urandom());
      attenIndiv = 1'($urandom());
      randomRun(300, "R4");
    end

    // R3 soft mute down and up
    attenLeft = 8'h00; attenRight = 8'h00; attenIndiv = 1'b0;
    randomRun(1100, "R3 settle");
    muteOn = 1'b1;
    randomRun(1024, "R3 down");
    lastS = 24'h400000;
    strobe(lastS, lastS, "R3 muted");
    chk(outLeft == 24'h0 && outRight == 24'h0, "R3 reached silence", 32'(outLeft), 32'd0);
    muteOn = 1'b0;
    randomRun(1024, "R3 up");
    strobe(lastS, lastS, "R3 released");
    chk(outLeft == lastS && outRight == lastS, "R3 back to unity", 32'(outLeft), 32'(lastS));

    // R10 mono routing
    monoOn = 1'b1; monoPickLeft = 1'b1;
    randomRun(300, "R10 left");
    monoPickLeft = 1'b0;
    randomRun(300, "R10 right");
    strobe(24'h111111, 24'h222222, "R10 pick right");
    chk(outLeft == 24'h222222, "R10 right to both", 32'(outLeft), 32'h222222);
    monoOn = 1'b0;

    // R6 threshold
    zeroDetEnN = 1'b0;
    strobe(24'h123456, 24'h654321, "R6 break");
    holdRun(24'h000007, 24'h123457, 1, "R6");
    for (int i = 0; i < 8191; i++) strobe(24'h000007, rnd() | 24'h100000, "R6 count");
    chk(zeroLeft == 1'b0, "R6 not yet at 8191", 32'(zeroLeft), 32'd0);
    strobe(24'h000007, 24'h345678, "R6 8192");
    chk(zeroLeft == 1'b1, "R6 flagged at 8192", 32'(zeroLeft), 32'd1);
    chk(outLeft == 24'h0, "R8 forced zero", 32'(outLeft), 32'd0);
    chk(zeroBoth == 1'b0, "R7 right still live", 32'(zeroBoth), 32'd0);

    // R10 with R8: flagged source drives both outputs to zero
    monoOn = 1'b1; monoPickLeft = 1'b1;
    holdRun(24'h000007, 24'h345678, 3, "R10 mono flagged");
    chk(outRight == 24'h0, "R8 mono follows source flag", 32'(outRight), 32'd0);
    monoOn = 1'b0;

    // R7 both channels quiet
    holdRun(24'h000007, 24'hFFFFF5, 8193, "R7");
    chk(zeroBoth == 1'b1, "R7 both flagged", 32'(zeroBoth), 32'd1);

    // R6 changed low nibble restarts the count
    strobe(24'h000008, 24'hFFFFF5, "R6 nibble");
    chk(zeroLeft == 1'b0 && zeroRight == 1'b1, "R6 nibble change clears left only",
        {30'd0, zeroLeft, zeroRight}, 32'd1);

    // R6 non-uniform upper bits never count
    holdRun(24'h000107, 24'hFFFFF5, 8300, "R6 upper");
    chk(zeroLeft == 1'b0, "R6 non-uniform never flagged", 32'(zeroLeft), 32'd0);

    // R9 disable clears flags and forcing, then re-enable restores them
    zeroDetEnN = 1'b1;
    #1;
    chk(!zeroLeft && !zeroRight && !zeroBoth, "R9 flags cleared", {29'd0, zeroLeft, zeroRight, zeroBoth}, 32'd0);
    chk(outRight == 24'hFFFFF5, "R9 output unforced", 32'(outRight), 32'hFFFFF5);
    zeroDetEnN = 1'b0;
    #1;
    chk(zeroRight == 1'b1 && outRight == 24'h0, "R9 re-enabled keeps count", 32'(outRight), 32'd0);
    @(negedge clk);
    zeroDetEnN = 1'b1;
    holdRun(24'h000107, 24'hFFFFF5, 20, "R9 disabled run");
    chk(outRight == 24'hFFFFF5, "R9 no forcing while disabled", 32'(outRight), 32'hFFFFF5);
    idle(3);

    finished = 1;
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      totalChecks++;
      failChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
      $finish;
    end
  end

endmodule